// File: doc/BRIEF.md
# ADC Conversion Clock and Sample-Window Timer

This block runs entirely in the fast peripheral clock domain. From that clock it builds a strobe that marks each period of the slower converter clock, and it times the sample/hold acquisition window that precedes each conversion. No derived or gated clock is created. Every output is a single-cycle enable or a level in the peripheral clock domain, so downstream converter logic can use the strobe as a clock enable.

The divider has two chained stages. The first stage divides by twice a 4-bit core prescale value, and a value of zero passes the input rate straight through. The second stage divides by one or by two, as a select bit chooses. A new prescale setting is adopted only when a stage reaches its terminal count, so a mid-period change never shortens a period. A start-of-sample pulse arms the window. The window opens on the next converter-clock strobe and stays open for a programmable number of whole converter-clock periods. A one-cycle done pulse marks the edge where the window closes. A combinational flag reports a configuration whose converter clock would be faster than the allowed maximum for the configured input frequency.

Top module: `adc_clk_acq_timer`

## Requirements
- R1: With the module enabled, `adc_tick` pulses once every D1*D2 input clocks. D1 is 1 when `core_div` is 0 and 2*`core_div` otherwise. D2 is 1 when `half_sel` is 0 and 2 when it is 1.
- R2: With the default 150 MHz input, `core_div`=3 and `half_sel`=0, the strobe period is 6 input clocks (25 MHz) and `cfg_too_fast` is low.
- R3: While `clk_en` is 0, `adc_tick` stays low. Dropping `clk_en` closes an open window with no `win_done`, and it also drops a pending start.
- R4: A change to `core_div` takes effect at the next first-stage terminal count. The strobe interval in progress keeps the old length, and the one after it uses the new length.
- R5: After a `sample_start` pulse, `sample_win` rises in the clock after the first `adc_tick` seen at or after the pulse. It then stays high for exactly (`acq_len`+1)*D1*D2 input clocks.
- R6: `win_done` is high for exactly one input clock. That clock is the first one in which `sample_win` is low again after the window.
- R7: A `sample_start` that arrives while a window is open is ignored. Exactly one window and one `win_done` result.
- R8: `cfg_too_fast` is high exactly when PCLK_HZ > ADC_MAX_HZ*D1*D2 for the current `core_div` and `half_sel`.
- R9: `acq_len` is captured when the window opens. Changing it during the window does not change the window length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_en | input | 1 | Module clock enable; no strobes while low |
| core_div | input | PS_W | First-stage prescale (divide by 2*value, 0 = bypass) |
| half_sel | input | 1 | Second-stage select: 0 = /1, 1 = /2 |
| acq_len | input | ACQ_W | Window length minus one, in converter clock periods |
| sample_start | input | 1 | Start-of-sample request pulse |
| adc_tick | output | 1 | One-cycle converter clock strobe |
| sample_win | output | 1 | High during the acquisition window |
| win_done | output | 1 | One-cycle pulse when the window closes |
| cfg_too_fast | output | 1 | Current divider setting exceeds the converter clock limit |

## Verification
The hardest case to reach from the ports is a prescale change that lands in the middle of a strobe interval. The bench has to tell apart an interval that finishes at the old length from one that is cut short or stretched. To get there, the bench locks onto a strobe, waits a few clocks, and rewrites `core_div`. It then measures the two intervals that follow against the old and the new divide ratios. Window tests also inject a second start request and an `acq_len` rewrite while the window is open. After the window closes, the bench keeps watching for several converter periods so that a wrongly latched request would show up as an extra window.

// File: rtl/adc_clk_acq_timer.sv
module adc_clk_acq_timer #(
  parameter longint unsigned PCLK_HZ    = 150_000_000,
  parameter longint unsigned ADC_MAX_HZ = 25_000_000,
  parameter int PS_W  = 4,
  parameter int ACQ_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en,
  input  logic [PS_W-1:0]  core_div,
  input  logic             half_sel,
  input  logic [ACQ_W-1:0] acq_len,
  input  logic             sample_start,
  output logic             adc_tick,
  output logic             sample_win,
  output logic             win_done,
  output logic             cfg_too_fast
);
  localparam int C1_W  = PS_W + 1;
  localparam int DIV_W = PS_W + 2;

  logic [C1_W-1:0]  c1_cnt, c1_lim, c1_next;
  logic             c2_cnt, c2_lim;
  logic             t1;
  logic             pend, win, done_q;
  logic [ACQ_W-1:0] acnt, acq_q;
  logic             open_w, last_w;
  logic [DIV_W-1:0] d1, d_tot;

  assign c1_next  = (core_div == '0) ? '0 : {core_div, 1'b0} - C1_W'(1);
  assign t1       = clk_en && (c1_cnt == c1_lim);
  assign adc_tick = t1 && (c2_cnt == c2_lim);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c1_cnt <= '0;
      c1_lim <= '0;
      c2_cnt <= 1'b0;
      c2_lim <= 1'b0;
    end else if (!clk_en) begin
      c1_cnt <= '0;
      c1_lim <= c1_next;
      c2_cnt <= 1'b0;
      c2_lim <= half_sel;
    end else if (t1) begin
      c1_cnt <= '0;
      c1_lim <= c1_next;
      if (c2_cnt == c2_lim) begin
        c2_cnt <= 1'b0;
        c2_lim <= half_sel;
      end else begin
        c2_cnt <= c2_cnt + 1'b1;
      end
    end else begin
      c1_cnt <= c1_cnt + C1_W'(1);
    end
  end

  assign open_w = adc_tick && !win && (pend || sample_start);
  assign last_w = win && adc_tick && (acnt == acq_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend   <= 1'b0;
      win    <= 1'b0;
      done_q <= 1'b0;
      acnt   <= '0;
      acq_q  <= '0;
    end else if (!clk_en) begin
      pend   <= 1'b0;
      win    <= 1'b0;
      done_q <= 1'b0;
      acnt   <= '0;
    end else begin
      done_q <= last_w;
      if (last_w)
        win <= 1'b0;
      else if (win && adc_tick)
        acnt <= acnt + 1'b1;
      if (open_w) begin
        win   <= 1'b1;
        pend  <= 1'b0;
        acnt  <= '0;
        acq_q <= acq_len;
      end else if (sample_start && !win) begin
        pend <= 1'b1;
      end
    end
  end

  assign sample_win = win;
  assign win_done   = done_q;

  assign d1           = (core_div == '0) ? DIV_W'(1) : DIV_W'({core_div, 1'b0});
  assign d_tot        = half_sel ? (d1 << 1) : d1;
  assign cfg_too_fast = PCLK_HZ > (ADC_MAX_HZ * 64'(d_tot));
endmodule

// File: rtl/adc_clk_acq_timer_chk.sv
module adc_clk_acq_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic clk_en,
  input logic adc_tick,
  input logic sample_win,
  input logic win_done
);
  a_r3_no_tick_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |-> !adc_tick);

  a_r3_disable_closes: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> (!sample_win && !win_done));

  a_r5_open_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sample_win) |-> $past(adc_tick));

  a_r6_done_at_close: assert property (@(posedge clk) disable iff (!rst_n)
    win_done |-> ($past(sample_win) && !sample_win && $past(adc_tick)));

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    win_done |=> !win_done);
endmodule

bind adc_clk_acq_timer adc_clk_acq_timer_chk u_chk (.*);

// File: tb/test_adc_clk_acq_timer.sv
`timescale 1ns/1ps
module test_adc_clk_acq_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clk_en = 1'b0;
  logic [3:0] core_div = '0;
  logic       half_sel = 1'b0;
  logic [3:0] acq_len = '0;
  logic       sample_start = 1'b0;
  logic       adc_tick, sample_win, win_done, cfg_too_fast;
  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  adc_clk_acq_timer i_adc_clk_acq_timer (.*);

  task automatic check(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  function automatic int per_of(int c, int s);
    return (c == 0 ? 1 : 2 * c) * (s != 0 ? 2 : 1);
  endfunction

  task automatic setup(int c, int s);
    clk_en = 1'b0;
    core_div = 4'(c);
    half_sel = s[0];
    step();
    step();
    clk_en = 1'b1;
  endtask

  task automatic wait_tick(output int n);
    n = 0;
    do begin
      step();
      n++;
    end while (!adc_tick && n < 400);
  endtask

  task automatic run_win(int c, int s, int acq, bit mid_start, bit mid_acq,
                         output int hi, output int dn, output int bad_align);
    int per;
    int done_k;
    bit prev;
    per = per_of(c, s);
    setup(c, s);
    acq_len = 4'(acq);
    step();
    step();
    sample_start = 1'b1;
    step();
    sample_start = 1'b0;
    hi = 0; dn = 0; bad_align = 0; done_k = -1; prev = 1'b0;
    for (int k = 0; k < 3000; k++) begin
      if (k > 0) step();
      sample_start = 1'b0;
      if (sample_win) hi++;
      if (win_done) begin
        dn++;
        if (!prev || sample_win) bad_align++;
        if (done_k < 0) done_k = k;
      end
      prev = sample_win;
      if (mid_start && hi == 2 && sample_win) sample_start = 1'b1;
      if (mid_acq && hi == 1) acq_len = 4'(15 - acq);
      if (done_k >= 0 && k >= done_k + 3 * per + 4) break;
    end
    sample_start = 1'b0;
  endtask

  initial begin
    #500000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int w;
    int hi, dn, ba, cnt;
    step();
    step();
    check("reset adc_tick", longint'(adc_tick), 0);
    check("reset sample_win", longint'(sample_win), 0);
    check("reset win_done", longint'(win_done), 0);
    rst_n = 1'b1;
    step();

    // R1 / R8: full sweep of the divider settings
    for (int c = 0; c < 16; c++) begin
      for (int s = 0; s < 2; s++) begin
        setup(c, s);
        check($sformatf("R8 flag c=%0d s=%0d", c, s), longint'(cfg_too_fast),
              (64'd150_000_000 > 64'd25_000_000 * 64'(per_of(c, s))) ? 1 : 0);
        wait_tick(w);
        for (int r = 0; r < 3; r++) begin
          wait_tick(w);
          check($sformatf("R1 period c=%0d s=%0d", c, s), w, per_of(c, s));
        end
      end
    end

    // R2 reference case
    setup(3, 0);
    wait_tick(w);
    wait_tick(w);
    check("R2 period", w, 6);
    check("R2 flag", longint'(cfg_too_fast), 0);

    // R3 no strobes while disabled
    clk_en = 1'b0;
    cnt = 0;
    for (int k = 0; k < 40; k++) begin
      step();
      if (adc_tick) cnt++;
    end
    check("R3 ticks while disabled", cnt, 0);

    // R4 mid-period divider change
    setup(4, 0);
    wait_tick(w);
    step(); step(); step();
    core_div = 4'd2;
    w = 3;
    do begin
      step();
      w++;
    end while (!adc_tick && w < 400);
    check("R4 interval at old ratio", w, 8);
    wait_tick(w);
    check("R4 interval at new ratio", w, 4);

    // R5 / R6: window length sweep
    for (int cfg = 0; cfg < 3; cfg++) begin
      for (int a = 0; a < 16; a++) begin
        int c = (cfg == 0) ? 0 : (cfg == 1 ? 1 : 3);
        int s = (cfg == 1) ? 1 : 0;
        run_win(c, s, a, 1'b0, 1'b0, hi, dn, ba);
        check($sformatf("R5 window c=%0d s=%0d acq=%0d", c, s, a), hi, (a + 1) * per_of(c, s));
        check($sformatf("R6 done count acq=%0d", a), dn, 1);
        check($sformatf("R6 done alignment acq=%0d", a), ba, 0);
      end
    end

    // R7 start during an open window
    run_win(1, 1, 5, 1'b1, 1'b0, hi, dn, ba);
    check("R7 window length with extra start", hi, 6 * 4);
    check("R7 single done", dn, 1);

    // R9 acq_len rewrite during window
    run_win(2, 0, 3, 1'b0, 1'b1, hi, dn, ba);
    check("R9 window keeps captured length", hi, 4 * 4);
    acq_len = 4'd0;

    // R3 abort by disable
    setup(1, 0);
    acq_len = 4'd7;
    sample_start = 1'b1;
    step();
    sample_start = 1'b0;
    w = 0;
    while (!sample_win && w < 50) begin
      step();
      w++;
    end
    step(); step(); step();
    clk_en = 1'b0;
    step();
    check("R3 window closed by disable", longint'(sample_win), 0);
    cnt = 0;
    for (int k = 0; k < 10; k++) begin
      if (win_done) cnt++;
      step();
    end
    clk_en = 1'b1;
    for (int k = 0; k < 40; k++) begin
      step();
      if (sample_win || win_done) cnt++;
    end
    check("R3 no done or window after abort", cnt, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule